// File: doc/BRIEF.md
# Entropy-Seeded Non-Blocking Random Source

This block supplies pseudo-random values that never stall their reader. The values come from a 256-bit linear feedback shift register (LFSR) with a fixed maximal-length feedback polynomial. Each time the processor starts a program, the block drops its ready flag and asks an external entropy source for a fresh seed over a request/acknowledge interface. The processor must hold off execution until the ready flag is high again.

Once the block is seeded, every step strobe moves the LFSR forward by one position. The current state is always visible at full width, and its least significant 32-bit word is also available for narrow register reads. A seed of all zeros would lock the register, so the block swaps such a seed for a fixed non-zero pattern.

Top module: `seeded_prng`

## Requirements
- R1: After reset `ready_o` and `ent_req_o` are 0 and `value_o` holds the fallback pattern, which is the 32-bit word 0x6A09E667 repeated eight times.
- R2: A cycle with `start_i` high drives `ent_req_o` high from the next cycle on. It stays high until an acknowledge is taken.
- R3: `ready_o` is low in the cycle after any `start_i` pulse, and `ent_req_o` and `ready_o` are never high together.
- R4: A cycle with `ent_req_o` and `ent_ack_i` both high loads `ent_data_i` into the state. In the next cycle `value_o` equals that seed, `ready_o` is 1 and `ent_req_o` is 0.
- R5: An all-zero seed is stored as the fallback pattern from R1.
- R6: A cycle with `ready_o` and `step_i` both high advances the state by one step. The next value is `{v[254:0], v[255]^v[253]^v[250]^v[245]}`.
- R7: `step_i` has no effect while `ready_o` is low, and `value_o` holds.
- R8: A `start_i` while a request is already pending issues no second request. `ent_req_o` stays high, and a single acknowledge completes the seeding.
- R9: When `start_i` and an acknowledge arrive in the same cycle, the seed is loaded. The request stays high and `ready_o` stays low until a further acknowledge.
- R10: `word_o` always equals bits 31:0 of `value_o`.
- R11: `ent_ack_i` is ignored while no request is pending, and the state does not change from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Program start strobe; triggers a reseed |
| step_i | input | 1 | Read strobe; advances the LFSR when ready |
| ent_ack_i | input | 1 | Entropy source acknowledge, carries valid seed |
| ent_data_i | input | 256 | Seed data from the entropy source |
| ent_req_o | output | 1 | Seed request to the entropy source |
| ready_o | output | 1 | State is seeded; execution may proceed |
| value_o | output | 256 | Current LFSR state |
| word_o | output | 32 | Least significant 32 bits of the state |

## Verification
Every result is registered once, so each effect of a stimulus is due exactly one cycle after the clock edge that samples it. This covers the request rising after a start, ready falling, the seed appearing and a step taking effect. `word_o` is the only output that follows `value_o` in the same cycle. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. It compares against a model that is updated once per edge, so each check falls in the first cycle the result is due. Checks of held values repeat over several later cycles to show that nothing moved.

// File: rtl/prng_pkg.sv
package prng_pkg;

  localparam int unsigned DefaultWidth = 256;

  // Feedback taps for x^256 + x^254 + x^251 + x^246 + 1 (bit index = exponent - 1)
  localparam logic [DefaultWidth-1:0] DefaultTaps =
      (256'b1 << 255) | (256'b1 << 253) | (256'b1 << 250) | (256'b1 << 245);

  // Substitute state for an all-zero seed
  localparam logic [DefaultWidth-1:0] DefaultFallback = {8{32'h6A09_E667}};

  typedef enum logic [1:0] {
    SeedIdle  = 2'd0,
    SeedWait  = 2'd1,
    SeedReady = 2'd2
  } seed_state_e;

endpackage

// File: rtl/prng_seed_ctrl.sv
module prng_seed_ctrl
  import prng_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ent_ack_i,
  output logic ent_req_o,
  output logic ready_o,
  output logic seed_load_o
);

  seed_state_e state_q, state_d;

  // A start always (re)arms the request; a pending request is simply kept.
  always_comb begin
    state_d = state_q;
    if (start_i) begin
      state_d = SeedWait;
    end else if (state_q == SeedWait && ent_ack_i) begin
      state_d = SeedReady;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SeedIdle;
    end else begin
      state_q <= state_d;
    end
  end

  assign ent_req_o   = (state_q == SeedWait);
  assign ready_o     = (state_q == SeedReady);
  assign seed_load_o = (state_q == SeedWait) && ent_ack_i;

endmodule

// File: rtl/prng_lfsr_core.sv
module prng_lfsr_core #(
  parameter int unsigned       WIDTH    = 256,
  parameter logic [WIDTH-1:0]  TAPS     = '1,
  parameter logic [WIDTH-1:0]  FALLBACK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seed_load_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic             step_i,
  output logic [WIDTH-1:0] state_o
);

  // One Fibonacci step: shift towards the MSB, feedback enters at bit 0.
  function automatic logic [WIDTH-1:0] lfsr_advance(input logic [WIDTH-1:0] s);
    return {s[WIDTH-2:0], ^(s & TAPS)};
  endfunction

  // Keep the register out of the all-zero lock-up state.
  function automatic logic [WIDTH-1:0] condition_seed(input logic [WIDTH-1:0] s);
    return (s == '0) ? FALLBACK : s;
  endfunction

  logic [WIDTH-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FALLBACK;
    end else if (seed_load_i) begin
      state_q <= condition_seed(seed_i);
    end else if (step_i) begin
      state_q <= lfsr_advance(state_q);
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/seeded_prng.sv
module seeded_prng #(
  parameter int unsigned      WIDTH    = prng_pkg::DefaultWidth,
  parameter int unsigned      WORD     = 32,
  parameter logic [WIDTH-1:0] TAPS     = prng_pkg::DefaultTaps,
  parameter logic [WIDTH-1:0] FALLBACK = prng_pkg::DefaultFallback
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  input  logic             ent_ack_i,
  input  logic [WIDTH-1:0] ent_data_i,
  output logic             ent_req_o,
  output logic             ready_o,
  output logic [WIDTH-1:0] value_o,
  output logic [WORD-1:0]  word_o
);

  // Internal events, named for the checker
  logic seed_load;
  logic step_fire;

  prng_seed_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .ent_ack_i   (ent_ack_i),
    .ent_req_o   (ent_req_o),
    .ready_o     (ready_o),
    .seed_load_o (seed_load)
  );

  assign step_fire = ready_o && step_i;

  prng_lfsr_core #(
    .WIDTH    (WIDTH),
    .TAPS     (TAPS),
    .FALLBACK (FALLBACK)
  ) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .seed_load_i (seed_load),
    .seed_i      (ent_data_i),
    .step_i      (step_fire),
    .state_o     (value_o)
  );

  assign word_o = value_o[WORD-1:0];

endmodule

// File: rtl/prng_checks.sv
module prng_checks #(
  parameter int unsigned WIDTH = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             step_i,
  input logic             ent_ack_i,
  input logic             ent_req_o,
  input logic             ready_o,
  input logic [WIDTH-1:0] value_o,
  input logic             seed_load,
  input logic             step_fire
);

  p_req_after_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ent_req_o);

  p_ready_drops_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !ready_o);

  p_req_ready_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ent_req_o && ready_o));

  p_ready_after_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_load && !start_i) |=> (ready_o && !ent_req_o));

  p_never_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    value_o != '0);

  p_step_moves_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_fire |=> value_o != $past(value_o));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_fire && !seed_load) |=> $stable(value_o));

  p_blocked_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ready_o && !seed_load) |=> $stable(value_o));

  p_ack_needs_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load |-> ent_req_o);

endmodule

bind seeded_prng prng_checks #(.WIDTH(WIDTH)) u_checks (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .step_i    (step_i),
  .ent_ack_i (ent_ack_i),
  .ent_req_o (ent_req_o),
  .ready_o   (ready_o),
  .value_o   (value_o),
  .seed_load (seed_load),
  .step_fire (step_fire)
);

// File: tb/seeded_prng_bench.sv
`timescale 1ns/1ps
module seeded_prng_bench;

  localparam int W = 256;
  localparam logic [W-1:0] FB = {8{32'h6A09_E667}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         step = 1'b0;
  logic         ack = 1'b0;
  logic [W-1:0] data = '0;
  logic         req;
  logic         ready;
  logic [W-1:0] value;
  logic [31:0]  word;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] model;

  always #4 clk = ~clk;

  seeded_prng u_seeded_prng (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .step_i     (step),
    .ent_ack_i  (ack),
    .ent_data_i (data),
    .ent_req_o  (req),
    .ready_o    (ready),
    .value_o    (value),
    .word_o     (word)
  );

  // Reference step written from R6
  function automatic logic [W-1:0] ref_step(input logic [W-1:0] v);
    logic fb;
    fb = v[255] ^ v[253] ^ v[250] ^ v[245];
    return {v[254:0], fb};
  endfunction

  task automatic chk_bit(input string req_id, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req_id, act, exp);
    end
  endtask

  task automatic chk_val(input string req_id, input logic [W-1:0] exp);
    checks++;
    if (value !== exp) begin
      fails++;
      $display("FAIL %s: value got %h expected %h", req_id, value, exp);
    end
    checks++;
    if (word !== exp[31:0]) begin
      fails++;
      $display("FAIL R10 (%s): word got %h expected %h", req_id, word, exp[31:0]);
    end
  endtask

  // Drive at negedge, let one rising edge pass, sample 1 ns later
  task automatic cycle(input logic s, input logic st, input logic a, input logic [W-1:0] d);
    @(negedge clk);
    start = s; step = st; ack = a; data = d;
    @(posedge clk);
    #1;
    start = 1'b0; step = 1'b0; ack = 1'b0;
  endtask

  task automatic t_reset();
    chk_bit("R1 ready", ready, 1'b0);
    chk_bit("R1 req", req, 1'b0);
    chk_val("R1", FB);
    model = FB;
  endtask

  task automatic t_seed(input logic [W-1:0] seed);
    cycle(1'b1, 1'b0, 1'b0, '0);
    chk_bit("R2 req", req, 1'b1);
    chk_bit("R3 ready", ready, 1'b0);
    for (int i = 0; i < 3; i++) begin
      cycle(1'b0, 1'b0, 1'b0, '0);
      chk_bit("R2 req held", req, 1'b1);
    end
    cycle(1'b0, 1'b0, 1'b1, seed);
    model = (seed == '0) ? FB : seed;
    chk_bit("R4 ready", ready, 1'b1);
    chk_bit("R4 req", req, 1'b0);
    chk_val("R4/R5 seed", model);
  endtask

  task automatic t_steps(input int n);
    for (int i = 0; i < n; i++) begin
      cycle(1'b0, 1'b1, 1'b0, '0);
      model = ref_step(model);
      chk_val("R6 step", model);
    end
    cycle(1'b0, 1'b0, 1'b0, '0);
    chk_val("R6 idle hold", model);
  endtask

  task automatic t_ack_ignored();
    cycle(1'b0, 1'b0, 1'b1, {8{32'hDEAD_BEEF}});
    chk_val("R11 ack while ready", model);
    chk_bit("R11 ready", ready, 1'b1);
    chk_bit("R11 req", req, 1'b0);
  endtask

  task automatic t_step_blocked();
    cycle(1'b1, 1'b0, 1'b0, '0);
    chk_bit("R3 ready drop", ready, 1'b0);
    for (int i = 0; i < 3; i++) begin
      cycle(1'b0, 1'b1, 1'b0, '0);
      chk_val("R7 blocked step", model);
    end
    cycle(1'b0, 1'b0, 1'b1, {8{32'h0123_4567}});
    model = {8{32'h0123_4567}};
    chk_val("R7 reseed", model);
  endtask

  task automatic t_double_start();
    cycle(1'b1, 1'b0, 1'b0, '0);
    cycle(1'b0, 1'b0, 1'b0, '0);
    cycle(1'b1, 1'b0, 1'b0, '0);
    chk_bit("R8 req kept", req, 1'b1);
    cycle(1'b0, 1'b0, 1'b1, {4{64'h0F1E_2D3C_4B5A_6978}});
    model = {4{64'h0F1E_2D3C_4B5A_6978}};
    chk_bit("R8 req done", req, 1'b0);
    chk_bit("R8 ready", ready, 1'b1);
    chk_val("R8 seed", model);
    for (int i = 0; i < 2; i++) begin
      cycle(1'b0, 1'b0, 1'b0, '0);
      chk_bit("R8 no new req", req, 1'b0);
    end
  endtask

  task automatic t_start_with_ack();
    cycle(1'b1, 1'b0, 1'b0, '0);
    cycle(1'b1, 1'b0, 1'b1, {8{32'hCAFE_F00D}});
    model = {8{32'hCAFE_F00D}};
    chk_val("R9 loaded", model);
    chk_bit("R9 req", req, 1'b1);
    chk_bit("R9 ready", ready, 1'b0);
    cycle(1'b0, 1'b0, 1'b1, {8{32'h1357_9BDF}});
    model = {8{32'h1357_9BDF}};
    chk_val("R9 second", model);
    chk_bit("R9 ready after", ready, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk_bit("R1 idle req", req, 1'b0);
    t_ack_ignored_idle();
    t_seed({32'h8000_0001, 192'h0, 32'h0000_0003});
    t_steps(6);
    t_ack_ignored();
    t_seed('0);
    t_steps(4);
    t_step_blocked();
    t_steps(3);
    t_double_start();
    t_start_with_ack();
    t_steps(5);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic t_ack_ignored_idle();
    cycle(1'b0, 1'b0, 1'b1, {8{32'h5555_AAAA}});
    chk_val("R11 ack while idle", model);
    chk_bit("R11 idle ready", ready, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule